// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block judges whether a 10 Mb/s twisted-pair link segment is usable. It watches for receive activity, which is either frame traffic or link test pulses already qualified upstream. It drops the link after a long silence. It brings the link back after a single frame or after a run of evenly spaced link pulses. While the local transmitter is idle, it also asks the line driver for a link test pulse at a fixed period.

When the link is bad, four enables close: transmit, receive, diagnostic loopback and the SQE test. Pulse generation and receive monitoring keep running, so the link can recover. Recovery does not wait for the local transmit request to fall, so it also works while a jabber inhibit holds transmit active.

All timing counts a prescaled tick, nominally 1 ms. `TICK_DIV` clock cycles make one tick, so a simulation can shrink every timer by lowering that one parameter. The block has no data streams: every pin is a plain control or status level, or a single-cycle strobe, with no handshake.

Top module: `link_integrity_proc`

## Requirements
- R1: With transmit idle, `link_pulse_req` is a single-cycle strobe issued every `PULSE_PERIOD` ticks (exactly `PULSE_PERIOD*TICK_DIV` cycles apart).
- R2: While `tx_active` and `tx_en` are both high, no link pulse is requested. After transmit goes idle, the next request comes between `PULSE_PERIOD-1` and `PULSE_PERIOD` ticks later, plus at most two cycles.
- R3: While the link is bad, link pulses keep being requested at the R1 period even if `tx_active` is high.
- R4: `tx_en`, `rx_en`, `lpbk_en` and `sqe_en` are all high when `link_good` is high and all low when it is low.
- R5: From the bad state, the link becomes good one cycle after the `RUN_THRESH`-th consecutive qualified link pulse is sampled.
- R6: A link pulse continues a run only if `GAP_MIN` to `GAP_MAX` ticks (inclusive) have passed since the previous pulse. Otherwise the run count restarts at 1. The first pulse after the link goes bad starts a run.
- R7: A single cycle of `rx_frame` while the link is bad makes the link good on the next cycle.
- R8: While the link is good, `FAIL_TIMEOUT` ticks with neither `rx_frame` nor `rx_link_pulse` make the link bad. The change comes between `FAIL_TIMEOUT-1` and `FAIL_TIMEOUT` ticks after the last activity.
- R9: After reset the link is bad: `link_good`, all enables, `led_on` and `link_pulse_req` are low.
- R10: A bad link recovers by R5 while `tx_active` stays high throughout.
- R11: While `link_chk_dis` is high, `link_good`, all enables and `led_on` are high regardless of line activity.
- R12: After `link_good` falls, `led_on` stays low until `LED_MIN_OFF` ticks have passed, even if the link is good again sooner. Otherwise it follows `link_good`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_frame | input | 1 | High while a receive frame is in progress |
| rx_link_pulse | input | 1 | One-cycle strobe per qualified received link test pulse |
| tx_active | input | 1 | Local transmit request level |
| link_chk_dis | input | 1 | High forces the link to be reported good |
| link_good | output | 1 | Link status, high when usable |
| link_pulse_req | output | 1 | One-cycle request to send a link test pulse |
| tx_en | output | 1 | Transmit path enable |
| rx_en | output | 1 | Receive path enable |
| lpbk_en | output | 1 | Transmit-to-receive loopback enable |
| sqe_en | output | 1 | SQE test enable |
| led_on | output | 1 | Link LED drive, high = lit |

## Verification
The assertions assume that `rx_link_pulse` arrives as an isolated one-cycle strobe, and that every input is held low or at a defined level from time zero. They also assume the inputs change only between clock edges. The bench therefore drives every input on the falling edge, never raises a link-pulse strobe for more than one cycle, and sets each input before reset is released. Pulse spacing in the run table is always a whole number of ticks or a single cycle. This lets each gap be classified as inside or outside the qualifying window without depending on where the prescaler phase falls.

// File: rtl/lip_pkg.sv
package lip_pkg;
  typedef enum logic {
    LNK_FAIL = 1'b0,
    LNK_GOOD = 1'b1
  } link_st_e;
endpackage

// File: rtl/lip_tick.sv
module lip_tick #(
  parameter int DIV = 125000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/lip_pulse_gen.sv
module lip_pulse_gen #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_busy,
  output logic lp_req
);
  localparam int W = $clog2(PERIOD + 1);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;
  logic         lp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lp_q  <= 1'b0;
    end else begin
      lp_q <= !tx_busy && tick && (cnt_q == LAST);
      if (tx_busy)                   cnt_q <= '0;
      else if (tick && cnt_q == LAST) cnt_q <= '0;
      else if (tick)                 cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lp_req = lp_q;

  // R1
  lp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_q |=> !lp_q);
  // R2
  lp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_q |-> !$past(tx_busy));
endmodule

// File: rtl/lip_link_mon.sv
module lip_link_mon
  import lip_pkg::*;
#(
  parameter int FAIL_TO    = 100,
  parameter int RUN_THRESH = 4,
  parameter int GAP_MIN    = 2,
  parameter int GAP_MAX    = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_frame,
  input  logic rx_lp,
  output logic good
);
  localparam int WI = $clog2(FAIL_TO + 1);
  localparam int WG = $clog2(GAP_MAX + 2);
  localparam int WR = $clog2(RUN_THRESH + 1);
  localparam logic [WI-1:0] IDLE_LAST = WI'(FAIL_TO - 1);
  localparam logic [WG-1:0] GAP_LO    = WG'(GAP_MIN);
  localparam logic [WG-1:0] GAP_HI    = WG'(GAP_MAX);
  localparam logic [WR:0]   RUN_HIT   = (WR+1)'(RUN_THRESH);

  link_st_e      st_q;
  logic [WI-1:0] idle_q;
  logic [WG-1:0] gap_q;
  logic [WR-1:0] run_q;
  logic          act;
  logic          gap_ok;
  logic [WR:0]   run_nx;

  assign act    = rx_frame || rx_lp;
  assign gap_ok = (gap_q >= GAP_LO) && (gap_q <= GAP_HI);

  always_comb begin
    if (run_q == '0 || gap_ok) run_nx = {1'b0, run_q} + 1'b1;
    else                       run_nx = (WR+1)'(1);
  end

  // silence timer
  always_ff @(posedge clk) begin
    if (!rst_n)                         idle_q <= '0;
    else if (act)                       idle_q <= '0;
    else if (tick && idle_q != IDLE_LAST) idle_q <= idle_q + 1'b1;
  end

  // spacing since the previous link pulse, saturating above the window
  always_ff @(posedge clk) begin
    if (!rst_n)                      gap_q <= '0;
    else if (rx_lp)                  gap_q <= '0;
    else if (tick && gap_q <= GAP_HI) gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= LNK_FAIL;
      run_q <= '0;
    end else begin
      case (st_q)
        LNK_GOOD: begin
          run_q <= '0;
          if (!act && tick && idle_q == IDLE_LAST) st_q <= LNK_FAIL;
        end
        default: begin
          if (rx_frame) begin
            st_q  <= LNK_GOOD;
            run_q <= '0;
          end else if (rx_lp) begin
            if (run_nx >= RUN_HIT) begin
              st_q  <= LNK_GOOD;
              run_q <= '0;
            end else begin
              run_q <= run_nx[WR-1:0];
            end
          end
        end
      endcase
    end
  end

  assign good = (st_q == LNK_GOOD);

  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < WR'(RUN_THRESH));
  // R7
  exit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LNK_GOOD && $past(st_q) == LNK_FAIL) |-> $past(act));
  // R8
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LNK_FAIL && $past(st_q) == LNK_GOOD) |-> $past(tick && !act));
endmodule

// File: rtl/lip_led_hold.sv
module lip_led_hold #(
  parameter int MIN_OFF = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic good_in,
  output logic led_raw
);
  localparam int W = $clog2(MIN_OFF + 1);
  localparam logic [W-1:0] LOAD = W'(MIN_OFF);

  logic         good_d;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      good_d <= 1'b0;
      hold_q <= '0;
    end else begin
      good_d <= good_in;
      if (good_d && !good_in)       hold_q <= LOAD;
      else if (tick && hold_q != '0) hold_q <= hold_q - 1'b1;
    end
  end

  assign led_raw = good_in && (hold_q == '0);

  // R12
  led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (good_d && !good_in) |=> (hold_q != '0 && !led_raw));
endmodule

// File: rtl/link_integrity_proc.sv
module link_integrity_proc #(
  parameter int TICK_DIV     = 125000,
  parameter int PULSE_PERIOD = 16,
  parameter int FAIL_TIMEOUT = 100,
  parameter int RUN_THRESH   = 4,
  parameter int GAP_MIN      = 2,
  parameter int GAP_MAX      = 150,
  parameter int LED_MIN_OFF  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_frame,
  input  logic rx_link_pulse,
  input  logic tx_active,
  input  logic link_chk_dis,
  output logic link_good,
  output logic link_pulse_req,
  output logic tx_en,
  output logic rx_en,
  output logic lpbk_en,
  output logic sqe_en,
  output logic led_on
);
  logic tick;
  logic mon_good;
  logic led_raw;
  logic tx_busy;

  lip_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  lip_link_mon #(
    .FAIL_TO(FAIL_TIMEOUT), .RUN_THRESH(RUN_THRESH),
    .GAP_MIN(GAP_MIN), .GAP_MAX(GAP_MAX)
  ) u_mon (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .rx_frame(rx_frame), .rx_lp(rx_link_pulse), .good(mon_good)
  );

  assign link_good = link_chk_dis || mon_good;
  assign tx_en     = link_good;
  assign rx_en     = link_good;
  assign lpbk_en   = link_good;
  assign sqe_en    = link_good;
  assign tx_busy   = tx_active && tx_en;

  lip_pulse_gen #(.PERIOD(PULSE_PERIOD)) u_pgen (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .tx_busy(tx_busy), .lp_req(link_pulse_req)
  );

  lip_led_hold #(.MIN_OFF(LED_MIN_OFF)) u_led (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .good_in(link_good), .led_raw(led_raw)
  );

  assign led_on = link_chk_dis || led_raw;

  // R11
  dis_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_chk_dis |-> (link_good && led_on && sqe_en));
  // R3
  fail_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(link_good) && $past(tick)) |-> !$past(tx_busy));
endmodule

// File: tb/link_integrity_proc_tb.sv
module link_integrity_proc_tb;
  localparam int DIV = 4;
  localparam int PER = 16;
  localparam int FTO = 100;
  localparam int LMO = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_frame = 1'b0, rx_link_pulse = 1'b0, tx_active = 1'b0, link_chk_dis = 1'b0;
  logic link_good, link_pulse_req, tx_en, rx_en, lpbk_en, sqe_en, led_on;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  link_integrity_proc #(.TICK_DIV(DIV), .PULSE_PERIOD(PER), .FAIL_TIMEOUT(FTO),
    .RUN_THRESH(4), .GAP_MIN(2), .GAP_MAX(150), .LED_MIN_OFF(LMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_frame(rx_frame), .rx_link_pulse(rx_link_pulse),
    .tx_active(tx_active), .link_chk_dis(link_chk_dis), .link_good(link_good),
    .link_pulse_req(link_pulse_req), .tx_en(tx_en), .rx_en(rx_en),
    .lpbk_en(lpbk_en), .sqe_en(sqe_en), .led_on(led_on));

  // run table: cycles since previous pulse, expected link_good after it
  localparam int NV = 11;
  localparam int GAPS [NV] = '{0, 20, 4, 8, 700, 20, 20, 1, 600, 20, 20};
  localparam bit EXPG [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lp_strobe();
    rx_link_pulse = 1'b1;
    @(negedge clk);
    rx_link_pulse = 1'b0;
  endtask

  task automatic frame_strobe();
    rx_frame = 1'b1;
    @(negedge clk);
    rx_frame = 1'b0;
  endtask

  task automatic wait_lp(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!link_pulse_req && n < 2000);
  endtask

  function automatic int en_vec();
    return {tx_en, rx_en, lpbk_en, sqe_en};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!link_good && en_vec() == 0 && !led_on && !link_pulse_req, "R9 reset",
          {link_good, led_on, link_pulse_req}, 0);

    // R1 period with transmit idle
    wait_lp(n);
    wait_lp(n);
    check(n == PER*DIV, "R1 period", n, PER*DIV);

    // R3 pulses continue while bad even with tx requested
    tx_active = 1'b1;
    wait_lp(n);
    wait_lp(n);
    check(n == PER*DIV, "R3 period during fail", n, PER*DIV);
    check(en_vec() == 0, "R4 enables low when bad", en_vec(), 0);
    tx_active = 1'b0;

    // R5/R6 run qualification table
    foreach (GAPS[i]) begin
      if (GAPS[i] > 1) idle(GAPS[i] - 1);
      lp_strobe();
      check(link_good == EXPG[i], $sformatf("R6 run vector %0d", i), link_good, EXPG[i]);
    end
    check(link_good, "R5 good after threshold run", link_good, 1);
    check(en_vec() == 15, "R4 enables high when good", en_vec(), 15);

    // R2 suppression while transmitting, restart after idle
    frame_strobe();
    tx_active = 1'b1;
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (link_pulse_req) n++;
    end
    check(n == 0, "R2 no pulse while transmitting", n, 0);
    tx_active = 1'b0;
    wait_lp(n);
    check(n >= (PER-1)*DIV && n <= PER*DIV + 2, "R2 first pulse after tx", n, PER*DIV);

    // R8 silence timeout
    frame_strobe();
    idle(390);
    check(link_good, "R8 still good before timeout", link_good, 1);
    idle(15);
    check(!link_good, "R8 bad after timeout", link_good, 0);
    check(en_vec() == 0 && !led_on, "R4 enables drop on timeout", en_vec(), 0);

    // R7 frame recovery, R12 LED hold
    frame_strobe();
    check(link_good, "R7 frame restores link", link_good, 1);
    rx_frame = 1'b1;
    idle(190);
    check(!led_on && link_good, "R12 LED held off", led_on, 0);
    idle(230);
    check(led_on, "R12 LED back on", led_on, 1);
    rx_frame = 1'b0;

    // R10 recovery while transmit stays requested
    tx_active = 1'b1;
    idle(410);
    check(!link_good, "R10 link dropped", link_good, 0);
    for (int k = 0; k < 4; k++) begin
      idle(19);
      lp_strobe();
    end
    check(link_good, "R10 recovered with tx active", link_good, 1);
    tx_active = 1'b0;

    // R11 disable forces good
    idle(410);
    check(!link_good, "R11 precondition bad", link_good, 0);
    link_chk_dis = 1'b1;
    @(negedge clk);
    check(link_good && led_on && en_vec() == 15, "R11 forced good",
          {link_good, led_on}, 3);
    idle(500);
    check(link_good && led_on, "R11 stays good in silence", link_good, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule